// File: doc/BRIEF.md
# Split-flap matrix positioning controller

This block sits on the host side of a matrix of split-flap elements. Each element is reached by a line address and a column address, which the block turns into active-low line and column selects. One active-low start line is shared by every element, and a shared active-low 6-bit position bus comes back from them. A command gives a line, a column and a target position code. The block then steps the addressed element until the element reports that code, and it signals done with the code it read.

Positioning is done by sequencing the shared select, start and bus lines, not by driving any motor directly. A falling edge on a column select asks every running element of that column to halt at its next valid flap. The block then lowers the line select and reads the bus. A mismatch re-arms the element with start low and releases the line select, so the element turns on by one or more flaps, and the stop-and-read cycle repeats after one flap interval. The setup, hold and flap intervals come from tick counters. A retry limit ends a command that cannot reach its target.

Top module: `flap_matrix_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, every line and column select is high, start is high, `cmd_ready` is 1, and `done`, `busy` and `error` are 0.
- R2: At most one line select and at most one column select are low at any time. Bit i of `line_sel_n` is the one for line address i, and bit j of `col_sel_n` is the one for column address j.
- R3: A line select is low only while a column select is also low.
- R4: Start is driven low only while the addressed column select is low. After a mismatched read, the element is re-armed with start low and both selects low, then the line select is released while start stays low.
- R5: Every bus read is preceded by a falling edge of the column select taken with the line select high. The line select is lowered only after that edge, and the bus is sampled at the end of the setup interval.
- R6: The bus carries the bitwise inverse of the position code. When the inverted value equals the target, `done` pulses for one cycle with `done_code` equal to the target, and the line select is released with start high, so the element stays stopped. An element that already shows the target finishes after a single read and is never started.
- R7: A bus value of all ones means the element is moving or not selected, and it never counts as a match. A target of 0 therefore always ends in error.
- R8: If MAX_TRIES reads go by without a match, `error` rises, `done` does not pulse and the block returns to idle. `error` stays set until the next command is accepted.
- R9: A command is accepted only while `cmd_ready` is 1. `cmd_valid` while busy has no effect on the command in progress or on any other element.
- R10: No element other than the addressed one is ever started, including those that share its line or its column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block is idle and accepts a command |
| cmd_line | input | LINE_W | Line address of the element |
| cmd_col | input | COL_W | Column address of the element |
| cmd_code | input | CODE_W | Target position code |
| line_sel_n | output | N_LINES | Active-low line selects |
| col_sel_n | output | N_COLS | Active-low column selects |
| start_n | output | 1 | Shared active-low start line |
| data_n | input | CODE_W | Shared active-low position bus (wired-AND) |
| done | output | 1 | One-cycle pulse when the target is reached |
| done_code | output | CODE_W | Code read on the final, matching read |
| busy | output | 1 | A command is in progress |
| error | output | 1 | Last command exhausted its retries |

## Verification
The assertions assume the position bus is settled by the end of each setup interval. They also assume an element puts its inverted code on the bus only while it is selected and stopped, and shows all ones otherwise. The bench meets this with a behavioural model of a four-by-four matrix. The model's bus output is a combinational function of the current selects and of each element's running state. Its elements start only on a select release with start low, and they halt at the first flap step after a column falling edge. The model's flap step is longer than the path from release to stop edge, so each start moves an element by exactly one flap, and every target reachable on the model's seven-flap wheel falls inside the retry limit.

// File: rtl/flap_pkg.sv
package flap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STOP,
      ST_READ,
      ST_ARM,
      ST_SPIN,
      ST_RUN,
      ST_FIN
   } flap_state_t;

   function automatic int flap_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/flap_tick_timer.sv
module flap_tick_timer #(
   parameter int TICK_DIV = 1,
   parameter int LEN_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   output logic             expired
);

   logic [LEN_W-1:0] cnt_q;
   logic             tick;

   generate
      if (TICK_DIV > 1) begin : g_prescale
         localparam int PRE_W = $clog2(TICK_DIV);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (load) begin
               pre_q <= PRE_W'(TICK_DIV - 1);
            end else if (cnt_q != '0) begin
               pre_q <= (pre_q == '0) ? PRE_W'(TICK_DIV - 1) : pre_q - 1'b1;
            end
         end

         assign tick = (pre_q == '0);
      end else begin : g_direct
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len;
      end else if (cnt_q != '0 && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = !load && (cnt_q == '0);

   // R5: a finished interval stays finished until the next load
   p_timer_parks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/flap_sel_decode.sv
module flap_sel_decode #(
   parameter int N = 16,
   parameter int W = 4
) (
   input  logic         en,
   input  logic [W-1:0] addr,
   output logic [N-1:0] sel_n
);

   initial begin
      assert (N >= 1 && N <= (1 << W))
         else $error("flap_sel_decode: N does not fit the address width");
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_sel
         assign sel_n[i] = !(en && (addr == W'(i)));
      end
   endgenerate

endmodule

// File: rtl/flap_seq.sv
module flap_seq
   import flap_pkg::*;
#(
   parameter int LINE_W    = 4,
   parameter int COL_W     = 6,
   parameter int CODE_W    = 6,
   parameter int LEN_W     = 8,
   parameter int SETUP_T   = 2,
   parameter int HOLD_T    = 2,
   parameter int FLAP_T    = 100,
   parameter int MAX_TRIES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [LINE_W-1:0] cmd_line,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic [CODE_W-1:0] data_n,
   input  logic              tmr_expired,
   output logic              tmr_load,
   output logic [LEN_W-1:0]  tmr_len,
   output logic              line_en,
   output logic              col_en,
   output logic              start_n,
   output logic [LINE_W-1:0] line_q,
   output logic [COL_W-1:0]  col_q,
   output logic              cmd_ready,
   output logic              done,
   output logic [CODE_W-1:0] done_code,
   output logic              busy,
   output logic              error
);

   localparam int TRY_W = $clog2(MAX_TRIES + 1);

   initial begin
      assert (MAX_TRIES >= 1) else $error("flap_seq: MAX_TRIES must be at least 1");
      assert (CODE_W >= 2) else $error("flap_seq: CODE_W too small");
   end

   flap_state_t       state_q, state_d;
   logic              ld_q;
   logic [CODE_W-1:0] tgt_q, code_q;
   logic [TRY_W-1:0]  tries_q;
   logic              ok_q, done_q, err_q;

   logic [CODE_W-1:0] rd_code;
   logic              moving, hit, last_try, sample;

   assign rd_code  = ~data_n;
   assign moving   = &data_n;
   assign hit      = !moving && (rd_code == tgt_q);
   assign last_try = (tries_q + TRY_W'(1)) >= TRY_W'(MAX_TRIES);
   assign sample   = (state_q == ST_READ) && tmr_expired;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (cmd_valid)   state_d = ST_STOP;
         ST_STOP: if (tmr_expired) state_d = ST_READ;
         ST_READ: if (tmr_expired) state_d = (hit || last_try) ? ST_FIN : ST_ARM;
         ST_ARM:  if (tmr_expired) state_d = ST_SPIN;
         ST_SPIN: if (tmr_expired) state_d = ST_RUN;
         ST_RUN:  if (tmr_expired) state_d = ST_STOP;
         ST_FIN:  if (tmr_expired) state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      line_en = 1'b0;
      col_en  = 1'b0;
      start_n = 1'b1;
      tmr_len = LEN_W'(HOLD_T);
      case (state_q)
         ST_STOP: begin col_en = 1'b1;                                   end
         ST_READ: begin col_en = 1'b1; line_en = 1'b1; tmr_len = LEN_W'(SETUP_T); end
         ST_ARM:  begin col_en = 1'b1; line_en = 1'b1; start_n = 1'b0;   end
         ST_SPIN: begin col_en = 1'b1;                 start_n = 1'b0;   end
         ST_RUN:  begin                                tmr_len = LEN_W'(FLAP_T); end
         ST_FIN:  begin col_en = 1'b1;                                   end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ld_q    <= 1'b0;
         tgt_q   <= '0;
         code_q  <= '0;
         tries_q <= '0;
         ok_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         line_q  <= '0;
         col_q   <= '0;
      end else begin
         state_q <= state_d;
         ld_q    <= (state_d != state_q);
         done_q  <= 1'b0;
         if (state_q == ST_IDLE && cmd_valid) begin
            line_q  <= cmd_line;
            col_q   <= cmd_col;
            tgt_q   <= cmd_code;
            tries_q <= '0;
            err_q   <= 1'b0;
         end
         if (sample) begin
            tries_q <= tries_q + TRY_W'(1);
            code_q  <= rd_code;
            ok_q    <= hit;
         end
         if (state_q == ST_FIN && tmr_expired) begin
            done_q <= ok_q;
            err_q  <= !ok_q;
         end
      end
   end

   assign tmr_load  = ld_q;
   assign cmd_ready = (state_q == ST_IDLE);
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign done_code = code_q;
   assign error     = err_q;

   // R1: an idle block drives nothing onto the matrix
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!line_en && !col_en && start_n));

   // R6: the reported code is the commanded target
   p_done_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_code == tgt_q));

   // R8: done and error never coincide, and the try count stays bounded
   p_done_not_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !error);
   p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= TRY_W'(MAX_TRIES));

   // R9: the latched command does not change while busy
   p_cmd_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(tgt_q) && $stable(line_q) && $stable(col_q)));

endmodule

// File: rtl/flap_matrix_ctrl.sv
module flap_matrix_ctrl
   import flap_pkg::*;
#(
   parameter int LINE_W    = 4,
   parameter int COL_W     = 6,
   parameter int N_LINES   = 16,
   parameter int N_COLS    = 64,
   parameter int CODE_W    = 6,
   parameter int TICK_DIV  = 50000,
   parameter int SETUP_T   = 2,
   parameter int HOLD_T    = 2,
   parameter int FLAP_T    = 100,
   parameter int MAX_TRIES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [LINE_W-1:0]  cmd_line,
   input  logic [COL_W-1:0]   cmd_col,
   input  logic [CODE_W-1:0]  cmd_code,
   output logic [N_LINES-1:0] line_sel_n,
   output logic [N_COLS-1:0]  col_sel_n,
   output logic               start_n,
   input  logic [CODE_W-1:0]  data_n,
   output logic               done,
   output logic [CODE_W-1:0]  done_code,
   output logic               busy,
   output logic               error
);

   localparam int MAX_T = flap_max3(SETUP_T, HOLD_T, FLAP_T);
   localparam int LEN_W = $clog2(MAX_T + 1);

   initial begin
      assert (TICK_DIV >= 1) else $error("flap_matrix_ctrl: TICK_DIV must be at least 1");
      assert (FLAP_T >= 1 && SETUP_T >= 1 && HOLD_T >= 1)
         else $error("flap_matrix_ctrl: intervals must be at least one tick");
   end

   logic              tmr_load, tmr_expired;
   logic [LEN_W-1:0]  tmr_len;
   logic              line_en, col_en;
   logic [LINE_W-1:0] line_q;
   logic [COL_W-1:0]  col_q;

   flap_seq #(
      .LINE_W(LINE_W), .COL_W(COL_W), .CODE_W(CODE_W), .LEN_W(LEN_W),
      .SETUP_T(SETUP_T), .HOLD_T(HOLD_T), .FLAP_T(FLAP_T), .MAX_TRIES(MAX_TRIES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_line(cmd_line), .cmd_col(cmd_col), .cmd_code(cmd_code),
      .data_n(data_n),
      .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_len(tmr_len),
      .line_en(line_en), .col_en(col_en), .start_n(start_n),
      .line_q(line_q), .col_q(col_q),
      .cmd_ready(cmd_ready), .done(done), .done_code(done_code),
      .busy(busy), .error(error)
   );

   flap_tick_timer #(.TICK_DIV(TICK_DIV), .LEN_W(LEN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_expired)
   );

   flap_sel_decode #(.N(N_LINES), .W(LINE_W)) u_line_dec (
      .en(line_en), .addr(line_q), .sel_n(line_sel_n)
   );

   flap_sel_decode #(.N(N_COLS), .W(COL_W)) u_col_dec (
      .en(col_en), .addr(col_q), .sel_n(col_sel_n)
   );

   // R2: one line and one column at most
   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~line_sel_n) && $onehot0(~col_sel_n));

   // R3: a line is only selected inside a selected column
   p_line_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sel_n != '1) |-> (col_sel_n != '1));

   // R4: start is only asserted toward a selected column
   p_start_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_n |-> (col_sel_n != '1));

   // R5: a line select falls only after its column edge has happened
   p_read_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((&$past(line_sel_n)) && !(&line_sel_n)) |-> !(&$past(col_sel_n)));

endmodule

// File: tb/test_flap_matrix_ctrl.sv
module test_flap_matrix_ctrl;

   localparam int LW = 2, CW = 2, NL = 4, NC = 4, DW = 6;
   localparam int NE = NL * NC;
   localparam int FLAPS = 7;
   localparam int STEP_CYC = 40;
   localparam int TRIES = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [LW-1:0] cmd_line = '0;
   logic [CW-1:0] cmd_col = '0;
   logic [DW-1:0] cmd_code = '0;
   logic [NL-1:0] line_sel_n;
   logic [NC-1:0] col_sel_n;
   logic          start_n;
   logic [DW-1:0] data_n;
   logic          done;
   logic [DW-1:0] done_code;
   logic          busy;
   logic          error;

   int nvec = 0;
   int nbad = 0;

   always #10 clk = ~clk;

   flap_matrix_ctrl #(
      .LINE_W(LW), .COL_W(CW), .N_LINES(NL), .N_COLS(NC), .CODE_W(DW),
      .TICK_DIV(2), .SETUP_T(2), .HOLD_T(2), .FLAP_T(6), .MAX_TRIES(TRIES)
   ) i_flap_matrix_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_line(cmd_line), .cmd_col(cmd_col), .cmd_code(cmd_code),
      .line_sel_n(line_sel_n), .col_sel_n(col_sel_n), .start_n(start_n),
      .data_n(data_n), .done(done), .done_code(done_code), .busy(busy), .error(error)
   );

   // ---------------- element matrix model ----------------
   int            pos[NE];
   bit            run[NE];
   bit            pend[NE];
   int            stc[NE];
   int            starts[NE];
   int            reads[NE];
   logic [NL-1:0] pl;
   logic [NC-1:0] pc;

   function automatic logic [DW-1:0] code_of(input int p);
      return DW'(p + 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NE; e++) begin
            pos[e] = 0; run[e] = 1'b0; pend[e] = 1'b0;
            stc[e] = 0; starts[e] = 0; reads[e] = 0;
         end
         pl = '1;
         pc = '1;
      end else begin
         for (int e = 0; e < NE; e++) begin
            int  l;
            int  c;
            bit  sel_now;
            bit  sel_was;
            l = e / NC;
            c = e % NC;
            sel_now = !line_sel_n[l] && !col_sel_n[c];
            sel_was = !pl[l] && !pc[c];
            if (sel_was && !sel_now && !start_n && !run[e]) begin
               run[e] = 1'b1; pend[e] = 1'b0; stc[e] = 0; starts[e]++;
            end
            if (pc[c] && !col_sel_n[c] && run[e]) pend[e] = 1'b1;
            if (pl[l] && !line_sel_n[l] && !pc[c] && !col_sel_n[c]) reads[e]++;
            if (run[e]) begin
               if (stc[e] == STEP_CYC - 1) begin
                  stc[e] = 0;
                  pos[e] = (pos[e] + 1) % FLAPS;
                  if (pend[e]) begin run[e] = 1'b0; pend[e] = 1'b0; end
               end else begin
                  stc[e]++;
               end
            end
         end
         pl = line_sel_n;
         pc = col_sel_n;
      end
   end

   always_comb begin
      data_n = '1;
      for (int e = 0; e < NE; e++) begin
         if (!line_sel_n[e / NC] && !col_sel_n[e % NC] && !run[e])
            data_n = data_n & ~code_of(pos[e]);
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int idx(input int l, input int c);
      return l * NC + c;
   endfunction

   function automatic int start_sum();
      int s = 0;
      for (int e = 0; e < NE; e++) s += starts[e];
      return s;
   endfunction

   // wait for the running command to end; count done pulses seen
   task automatic wait_end(output int nd, output bit to);
      nd = 0;
      to = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         if (done) nd++;
         if (!busy) begin to = 1'b0; break; end
         @(negedge clk);
      end
   endtask

   task automatic issue(input int l, input int c, input int code);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_line  = LW'(l);
      cmd_col   = CW'(c);
      cmd_code  = DW'(code);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // command expected to reach its target
   task automatic t_reach(input string name, input int l, input int c, input int code);
      int nd; bit to; int e; int r0; int s_other;
      e = idx(l, c);
      r0 = reads[e];
      s_other = start_sum() - starts[e];
      issue(l, c, code);
      chk(busy == 1'b1, "R9", {name, " busy after accept"}, busy, 1);
      wait_end(nd, to);
      chk(!to, "R6", {name, " finished"}, to, 0);
      chk(nd == 1, "R6", {name, " done pulses"}, nd, 1);
      chk(done_code == DW'(code), "R6", {name, " done_code"}, done_code, code);
      chk(error == 1'b0, "R8", {name, " error low"}, error, 0);
      chk(reads[e] - r0 <= TRIES, "R8", {name, " reads within limit"}, reads[e] - r0, TRIES);
      @(negedge clk);
      chk(done == 1'b0, "R6", {name, " done one cycle"}, done, 0);
      chk(line_sel_n == '1 && col_sel_n == '1 && start_n == 1'b1, "R1",
          {name, " idle outputs"}, {line_sel_n, col_sel_n, start_n}, '1);
      repeat (60) @(negedge clk);
      chk(run[e] == 1'b0, "R6", {name, " element stays stopped"}, run[e], 0);
      chk(code_of(pos[e]) == DW'(code), "R6", {name, " element position"},
          code_of(pos[e]), code);
      chk(start_sum() - starts[e] == s_other, "R10", {name, " no other element started"},
          start_sum() - starts[e], s_other);
   endtask

   task automatic t_reset;
      chk(line_sel_n == '1, "R1", "reset line selects", line_sel_n, '1);
      chk(col_sel_n == '1, "R1", "reset column selects", col_sel_n, '1);
      chk(start_n == 1'b1, "R1", "reset start", start_n, 1);
      chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
      chk(done == 1'b0 && busy == 1'b0 && error == 1'b0, "R1", "reset flags",
          {done, busy, error}, 0);
   endtask

   task automatic t_already_there;
      int e; int r0; int s0;
      e = idx(1, 2);
      r0 = reads[e];
      s0 = starts[e];
      t_reach("already-there", 1, 2, 1);
      chk(reads[e] - r0 == 1, "R6", "already-there single read", reads[e] - r0, 1);
      chk(starts[e] == s0, "R6", "already-there never started", starts[e], s0);
   endtask

   task automatic t_select_map;
      // watch the selects during a read of element (2,3): bit 2 of line, bit 3 of column
      bit seen;
      seen = 1'b0;
      issue(2, 3, 1);
      for (int i = 0; i < 200; i++) begin
         if (line_sel_n != '1) begin
            seen = 1'b1;
            chk(line_sel_n == 4'b1011, "R2", "line select bit", line_sel_n, 4'b1011);
            chk(col_sel_n == 4'b0111, "R3", "column held with line", col_sel_n, 4'b0111);
            break;
         end
         @(negedge clk);
      end
      chk(seen, "R5", "line select lowered for read", seen, 1);
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   task automatic t_fail(input string name, input int l, input int c, input int code);
      int nd; bit to; int e; int r0; int s_other;
      e = idx(l, c);
      r0 = reads[e];
      s_other = start_sum() - starts[e];
      issue(l, c, code);
      wait_end(nd, to);
      chk(!to, "R8", {name, " finished"}, to, 0);
      chk(nd == 0, "R8", {name, " no done"}, nd, 0);
      chk(error == 1'b1, name == "zero-target" ? "R7" : "R8", {name, " error set"}, error, 1);
      chk(reads[e] - r0 == TRIES, "R8", {name, " read count"}, reads[e] - r0, TRIES);
      repeat (80) @(negedge clk);
      chk(error == 1'b1, "R8", {name, " error held"}, error, 1);
      chk(run[e] == 1'b0, "R4", {name, " element stopped after give-up"}, run[e], 0);
      chk(start_sum() - starts[e] == s_other, "R10", {name, " no other element started"},
          start_sum() - starts[e], s_other);
   endtask

   task automatic t_busy_ignored;
      int nd; bit to; int eo; int r0; int s0;
      eo = idx(0, 3);
      r0 = reads[eo];
      s0 = starts[eo];
      issue(2, 1, 3);
      chk(error == 1'b0, "R8", "error cleared by new command", error, 1'b0);
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b0, "R9", "ready low while busy", cmd_ready, 0);
      cmd_valid = 1'b1;
      cmd_line  = LW'(0);
      cmd_col   = CW'(3);
      cmd_code  = DW'(4);
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      wait_end(nd, to);
      chk(!to && nd == 1, "R9", "first command completes", nd, 1);
      chk(done_code == DW'(3), "R9", "target kept", done_code, 3);
      repeat (60) @(negedge clk);
      chk(busy == 1'b0, "R9", "late request not taken", busy, 0);
      chk(reads[eo] == r0 && starts[eo] == s0, "R9", "other element untouched",
          reads[eo] - r0 + starts[eo] - s0, 0);
      chk(code_of(pos[eo]) == DW'(1), "R9", "other element position", code_of(pos[eo]), 1);
   endtask

   // ---------------- sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_already_there;
      t_reach("move", 1, 2, 5);
      t_reach("wrap", 1, 2, 2);
      t_reach("corner", 3, 3, 7);
      t_select_map;
      t_fail("unreachable", 0, 0, 9);
      t_fail("zero-target", 2, 0, 0);
      t_busy_ignored;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule